// File: doc/BRIEF.md
# CSR Access Permission Checker

This block decides, in a single combinational pass, whether an instruction may touch a given control/status register. It classifies the 12-bit register address into a group: floating point, vector, counter, counter upper half, supervisor, hypervisor, memory protection, or unmatched. It then applies that group's rule against the core's current state. That state is the privilege level, whether a guest is running (virtualization active), which extensions are present, the floating-point enable status, debug mode, the base width (32 or 64 bit), and the two 32-bit counter-enable words, one from the machine level and one from the hypervisor level.

The verdict has three values: allowed, illegal instruction, or virtual-instruction fault. The pipeline uses the verdict to either let the access proceed or raise the matching trap. The block also provides a registered copy of the verdict for paths that need the timing margin. Register storage, data movement and trap entry are handled elsewhere.

Top module: `csr_gate`

## Requirements
- R1: The verdict uses the codes 0 for allowed, 1 for illegal instruction and 2 for virtual-instruction fault. Code 3 never appears.
- R2: Address 0x003 (the combined floating-point control word) is allowed whenever the vector extension is present, whatever the floating-point state or debug mode.
- R3: The floating-point addresses 0x001–0x003, outside the case in R2, are illegal unless debug mode is active or both the F extension is present and the floating-point status is on.
- R4: The vector addresses 0x008, 0x009, 0x00A, 0x00F and 0xC20–0xC22 are illegal when the vector extension is absent and allowed when it is present.
- R5: The counter addresses 0xC00–0xC1F are illegal when the counter feature is off.
- R6: With counters on and virtualization active, a counter access faults with code 2 when bit addr[4:0] is clear in the hypervisor enable word and set in the machine enable word. In every other case with counters on, the access is allowed.
- R7: The upper-half counter addresses 0xC80–0xC9F are illegal on a 64-bit core. On a 32-bit core they follow R5 and R6, using the bit addr[4:0].
- R8: The supervisor addresses 0x100, 0x104–0x106, 0x140–0x144 and 0x180 are illegal without the S extension and allowed with it.
- R9: The hypervisor and guest-supervisor addresses 0x200, 0x204, 0x205, 0x240–0x244, 0x280, 0x600, 0x602–0x607, 0x643–0x645, 0x64A, 0x680 and 0xE12 follow one rule. They are illegal unless both S and H are present. With both present, they are allowed at privilege 3 (machine) and at privilege 1 (supervisor) with virtualization off. Every other privilege state faults with code 2, including privilege 0 (user) and the reserved code 2.
- R10: The memory-protection addresses 0x3A0–0x3A3 and 0x3B0–0x3BF are illegal when the protection feature is absent and allowed when it is present.
- R11: Any address outside the groups listed above is illegal.
- R12: The registered output equals the combinational verdict of the previous clock cycle. It reads 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the registered verdict |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_addr_i | input | 12 | Register address being accessed |
| priv_i | input | 2 | Privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Virtualization active |
| ext_f_i | input | 1 | F extension present |
| ext_v_i | input | 1 | Vector extension present |
| ext_s_i | input | 1 | S extension present |
| ext_h_i | input | 1 | H extension present |
| ext_cnt_i | input | 1 | Counter feature enabled |
| ext_pmp_i | input | 1 | Memory-protection feature present |
| fs_on_i | input | 1 | Floating-point status on |
| debug_i | input | 1 | Debug mode active |
| rv32_i | input | 1 | Core runs 32-bit base |
| mcnt_en_i | input | 32 | Machine counter-enable word |
| hcnt_en_i | input | 32 | Hypervisor counter-enable word |
| result_o | output | 2 | Combinational verdict |
| result_q_o | output | 2 | Verdict registered one cycle |

## Verification
Two sweeps exercise the verdict. The first drives all 4096 addresses under 64 scattered configurations. This separates the group boundaries and shows that unmatched addresses stay illegal. The second drives every combination of the twelve state bits over a set of representative addresses, with counter-enable words that vary per vector. It separates the priority orderings: the vector override of the floating-point check before debug; the base-width check before the counter-off check before the virtual fault on upper halves; and the extension check before privilege on hypervisor registers. A short clocked sequence then shows that the registered copy trails the combinational verdict by exactly one cycle.

// File: rtl/csr_gate_pkg.sv
package csr_gate_pkg;

  localparam int ADDR_W = 12;

  typedef enum logic [1:0] {
    RES_OK   = 2'd0,
    RES_ILL  = 2'd1,
    RES_VIRT = 2'd2
  } res_e;

  typedef enum logic [3:0] {
    G_NONE,
    G_FP,
    G_FCSR,
    G_VEC,
    G_CNT,
    G_CNTH,
    G_SUP,
    G_HYP,
    G_PMP
  } grp_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [ADDR_W-1:0] A_FFLAGS  = 12'h001;
  localparam logic [ADDR_W-1:0] A_FRM     = 12'h002;
  localparam logic [ADDR_W-1:0] A_FCSR    = 12'h003;
  localparam logic [ADDR_W-1:0] A_CNT_LO  = 12'hC00;
  localparam logic [ADDR_W-1:0] A_CNTH_LO = 12'hC80;
  localparam logic [ADDR_W-1:0] A_PMPCFG  = 12'h3A0;
  localparam logic [ADDR_W-1:0] A_PMPADDR = 12'h3B0;

endpackage

// File: rtl/csr_gate_decode.sv
module csr_gate_decode
  import csr_gate_pkg::*;
#(
  parameter int NUM_CNT     = 32,
  parameter int PMP_ENTRIES = 16,
  localparam int IDX_W      = $clog2(NUM_CNT)
) (
  input  logic [ADDR_W-1:0] addr_i,
  output grp_e              grp_o,
  output logic [IDX_W-1:0]  idx_o
);

  localparam int PMPCFG_N = PMP_ENTRIES / 4;

  logic in_cnt, in_cnth, in_pmp;

  assign in_cnt  = (addr_i >= A_CNT_LO)  && (addr_i < A_CNT_LO  + ADDR_W'(NUM_CNT));
  assign in_cnth = (addr_i >= A_CNTH_LO) && (addr_i < A_CNTH_LO + ADDR_W'(NUM_CNT));
  assign in_pmp  = ((addr_i >= A_PMPCFG)  && (addr_i < A_PMPCFG  + ADDR_W'(PMPCFG_N))) ||
                   ((addr_i >= A_PMPADDR) && (addr_i < A_PMPADDR + ADDR_W'(PMP_ENTRIES)));

  assign idx_o = addr_i[IDX_W-1:0];

  always_comb begin
    grp_o = G_NONE;
    if (addr_i == A_FCSR) begin
      grp_o = G_FCSR;
    end else if (addr_i inside {A_FFLAGS, A_FRM}) begin
      grp_o = G_FP;
    end else if (addr_i inside {12'h008, 12'h009, 12'h00A, 12'h00F, [12'hC20:12'hC22]}) begin
      grp_o = G_VEC;
    end else if (in_cnt) begin
      grp_o = G_CNT;
    end else if (in_cnth) begin
      grp_o = G_CNTH;
    end else if (addr_i inside {12'h100, [12'h104:12'h106], [12'h140:12'h144], 12'h180}) begin
      grp_o = G_SUP;
    end else if (addr_i inside {12'h200, 12'h204, 12'h205, [12'h240:12'h244], 12'h280,
                                12'h600, [12'h602:12'h607], [12'h643:12'h645], 12'h64A,
                                12'h680, 12'hE12}) begin
      grp_o = G_HYP;
    end else if (in_pmp) begin
      grp_o = G_PMP;
    end
  end

endmodule

// File: rtl/csr_gate_cnt.sv
module csr_gate_cnt
  import csr_gate_pkg::*;
#(
  parameter int NUM_CNT = 32,
  localparam int IDX_W  = $clog2(NUM_CNT)
) (
  input  logic [IDX_W-1:0]   idx_i,
  input  logic               high_i,
  input  logic               rv32_i,
  input  logic               ext_cnt_i,
  input  logic               virt_i,
  input  logic [NUM_CNT-1:0] mcnt_en_i,
  input  logic [NUM_CNT-1:0] hcnt_en_i,
  output res_e               res_o
);

  // guest blocked by hypervisor while machine level grants it
  logic [NUM_CNT-1:0] vblock;

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_vblk
    assign vblock[i] = ~hcnt_en_i[i] & mcnt_en_i[i];
  end

  always_comb begin
    if (high_i && !rv32_i)             res_o = RES_ILL;
    else if (!ext_cnt_i)               res_o = RES_ILL;
    else if (virt_i && vblock[idx_i])  res_o = RES_VIRT;
    else                               res_o = RES_OK;
  end

endmodule

// File: rtl/csr_gate_policy.sv
module csr_gate_policy
  import csr_gate_pkg::*;
(
  input  grp_e       grp_i,
  input  res_e       cnt_res_i,
  input  logic [1:0] priv_i,
  input  logic       virt_i,
  input  logic       ext_f_i,
  input  logic       ext_v_i,
  input  logic       ext_s_i,
  input  logic       ext_h_i,
  input  logic       ext_pmp_i,
  input  logic       fs_on_i,
  input  logic       debug_i,
  output res_e       res_o
);

  logic fp_ok, hyp_priv_ok;

  assign fp_ok       = (ext_f_i & fs_on_i) | debug_i;
  assign hyp_priv_ok = (priv_i == PRIV_M) || ((priv_i == PRIV_S) && !virt_i);

  always_comb begin
    unique case (grp_i)
      G_FCSR:        res_o = (ext_v_i || fp_ok) ? RES_OK : RES_ILL;
      G_FP:          res_o = fp_ok ? RES_OK : RES_ILL;
      G_VEC:         res_o = ext_v_i ? RES_OK : RES_ILL;
      G_CNT, G_CNTH: res_o = cnt_res_i;
      G_SUP:         res_o = ext_s_i ? RES_OK : RES_ILL;
      G_HYP: begin
        if (!(ext_s_i && ext_h_i)) res_o = RES_ILL;
        else if (hyp_priv_ok)      res_o = RES_OK;
        else                       res_o = RES_VIRT;
      end
      G_PMP:         res_o = ext_pmp_i ? RES_OK : RES_ILL;
      default:       res_o = RES_ILL;
    endcase
  end

endmodule

// File: rtl/csr_gate.sv
module csr_gate
  import csr_gate_pkg::*;
#(
  parameter int NUM_CNT     = 32,
  parameter int PMP_ENTRIES = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [11:0]        csr_addr_i,
  input  logic [1:0]         priv_i,
  input  logic               virt_i,
  input  logic               ext_f_i,
  input  logic               ext_v_i,
  input  logic               ext_s_i,
  input  logic               ext_h_i,
  input  logic               ext_cnt_i,
  input  logic               ext_pmp_i,
  input  logic               fs_on_i,
  input  logic               debug_i,
  input  logic               rv32_i,
  input  logic [NUM_CNT-1:0] mcnt_en_i,
  input  logic [NUM_CNT-1:0] hcnt_en_i,
  output logic [1:0]         result_o,
  output logic [1:0]         result_q_o
);

  localparam int IDX_W = $clog2(NUM_CNT);

  grp_e             grp;
  logic [IDX_W-1:0] idx;
  res_e             cnt_res, res_c;

  csr_gate_decode #(.NUM_CNT(NUM_CNT), .PMP_ENTRIES(PMP_ENTRIES)) u_decode (
    .addr_i (csr_addr_i),
    .grp_o  (grp),
    .idx_o  (idx)
  );

  csr_gate_cnt #(.NUM_CNT(NUM_CNT)) u_cnt (
    .idx_i     (idx),
    .high_i    (grp == G_CNTH),
    .rv32_i    (rv32_i),
    .ext_cnt_i (ext_cnt_i),
    .virt_i    (virt_i),
    .mcnt_en_i (mcnt_en_i),
    .hcnt_en_i (hcnt_en_i),
    .res_o     (cnt_res)
  );

  csr_gate_policy u_policy (
    .grp_i     (grp),
    .cnt_res_i (cnt_res),
    .priv_i    (priv_i),
    .virt_i    (virt_i),
    .ext_f_i   (ext_f_i),
    .ext_v_i   (ext_v_i),
    .ext_s_i   (ext_s_i),
    .ext_h_i   (ext_h_i),
    .ext_pmp_i (ext_pmp_i),
    .fs_on_i   (fs_on_i),
    .debug_i   (debug_i),
    .res_o     (res_c)
  );

  assign result_o = res_c;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) result_q_o <= RES_OK;
    else         result_q_o <= result_o;
  end

  // R1
  res_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    result_o != 2'd3);

  // R2
  fcsr_vec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_addr_i == A_FCSR && ext_v_i) |-> result_o == RES_OK);

  // R5
  cnt_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp == G_CNT && !ext_cnt_i) |-> result_o == RES_ILL);

  // R7
  cnth_rv64_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp == G_CNTH && !rv32_i) |-> result_o == RES_ILL);

  // R9
  hyp_user_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp == G_HYP && ext_s_i && ext_h_i && priv_i == PRIV_U) |-> result_o == RES_VIRT);

  // R11
  nomatch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (grp == G_NONE) |-> result_o == RES_ILL);

  // R12
  reg_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> result_q_o == $past(result_o));

endmodule

// File: tb/tb_csr_gate.sv
module tb_csr_gate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  priv = '0;
  logic        virt = 0, ef = 0, ev = 0, es = 0, eh = 0, ec = 0, ep = 0, fs = 0, dbg = 0, r32 = 0;
  logic [31:0] mc = '0, hc = '0;
  logic [1:0]  res, res_q;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  csr_gate dut (
    .clk_i(clk), .rst_ni(rst_n), .csr_addr_i(addr), .priv_i(priv), .virt_i(virt),
    .ext_f_i(ef), .ext_v_i(ev), .ext_s_i(es), .ext_h_i(eh), .ext_cnt_i(ec),
    .ext_pmp_i(ep), .fs_on_i(fs), .debug_i(dbg), .rv32_i(r32),
    .mcnt_en_i(mc), .hcnt_en_i(hc), .result_o(res), .result_q_o(res_q)
  );

  function automatic bit is_sup(input logic [11:0] a);
    return a inside {12'h100, [12'h104:12'h106], [12'h140:12'h144], 12'h180};
  endfunction

  function automatic bit is_hyp(input logic [11:0] a);
    return a inside {12'h200, 12'h204, 12'h205, [12'h240:12'h244], 12'h280, 12'h600,
                     [12'h602:12'h607], [12'h643:12'h645], 12'h64A, 12'h680, 12'hE12};
  endfunction

  function automatic logic [1:0] model();
    logic [4:0] k;
    k = addr[4:0];
    if (addr == 12'h003 && ev) return 2'd0;                                   // R2
    if (addr inside {[12'h001:12'h003]}) return (dbg || (ef && fs)) ? 2'd0 : 2'd1; // R3
    if (addr inside {12'h008, 12'h009, 12'h00A, 12'h00F, [12'hC20:12'hC22]})
      return ev ? 2'd0 : 2'd1;                                                // R4
    if (addr[11:5] == 7'h60 || addr[11:5] == 7'h64) begin                     // R5 R6 R7
      if (addr[11:5] == 7'h64 && !r32) return 2'd1;
      if (!ec) return 2'd1;
      if (virt && !hc[k] && mc[k]) return 2'd2;
      return 2'd0;
    end
    if (is_sup(addr)) return es ? 2'd0 : 2'd1;                                // R8
    if (is_hyp(addr)) begin                                                   // R9
      if (!(es && eh)) return 2'd1;
      if (priv == 2'd3 || (priv == 2'd1 && !virt)) return 2'd0;
      return 2'd2;
    end
    if (addr inside {[12'h3A0:12'h3A3], [12'h3B0:12'h3BF]}) return ep ? 2'd0 : 2'd1; // R10
    return 2'd1;                                                              // R11
  endfunction

  function automatic string tag();
    if (addr == 12'h003 && ev) return "R2";
    if (addr inside {[12'h001:12'h003]}) return "R3";
    if (addr inside {12'h008, 12'h009, 12'h00A, 12'h00F, [12'hC20:12'hC22]}) return "R4";
    if (addr[11:5] == 7'h64) return "R7";
    if (addr[11:5] == 7'h60) return (ec && virt) ? "R6" : "R5";
    if (is_sup(addr)) return "R8";
    if (is_hyp(addr)) return "R9";
    if (addr inside {[12'h3A0:12'h3A3], [12'h3B0:12'h3BF]}) return "R10";
    return "R11";
  endfunction

  task automatic check(input string t, input logic [1:0] got, input logic [1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s addr=%h priv=%0d virt=%0b got %0d expected %0d", t, addr, priv, virt, got, exp);
    end
  endtask

  task automatic set_cfg(input logic [31:0] c);
    ef = c[0]; ev = c[1]; es = c[2]; eh = c[3]; ec = c[4]; ep = c[5];
    fs = c[6]; dbg = c[7]; r32 = c[8]; virt = c[9]; priv = c[11:10];
  endtask

  task automatic apply();
    #1;
    check(tag(), res, model());
    n_chk++;
    if (res === 2'd3) begin
      n_bad++;
      $display("FAIL R1 addr=%h got 3 expected 0..2", addr);
    end
    #1;
  endtask

  localparam int NREP = 14;
  logic [11:0] rep [NREP] = '{12'h001, 12'h002, 12'h003, 12'h008, 12'hC21, 12'hC00,
                              12'hC05, 12'hC9F, 12'hC83, 12'h100, 12'h600, 12'h244,
                              12'h3BF, 12'h7C0};

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset value
    check("R12", res_q, 2'd0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    // sweep A: every address, scattered configurations
    for (int k = 0; k < 64; k++) begin
      logic [31:0] c;
      c = 32'(k) * 32'h9E37_79B1;
      set_cfg(c >> 7);
      mc = c * 32'h85EB_CA6B;
      hc = {mc[15:0], mc[31:16]} ^ c;
      for (int a = 0; a < 4096; a++) begin
        addr = 12'(a);
        apply();
      end
    end
    // sweep B: every state combination, representative addresses
    for (int k = 0; k < 4096; k++) begin
      set_cfg(32'(k));
      for (int j = 0; j < NREP; j++) begin
        addr = rep[j];
        mc = 32'(k * 13 + j) * 32'h2545_F491;
        hc = 32'(k * 7 + j) * 32'h9E37_79B9;
        apply();
      end
    end
    // R12 registered copy, one cycle behind
    for (int j = 0; j < NREP; j++) begin
      logic [1:0] e;
      @(negedge clk);
      addr = rep[j];
      set_cfg(32'(j * 311));
      #1;
      e = model();
      @(negedge clk);
      check("R12", res_q, e);
    end
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

endmodule